// File: doc/BRIEF.md
# Orthogonal Row/Column Memory Fabric

This block joins `NPROC` processors to an `NPROC` x `NPROC` grid of small memory banks. There are `NPROC` row buses and `NPROC` column buses, and no bus is ever shared. In row mode, processor i owns row bus i and can reach every bank in row i. In column mode, processor j owns column bus j and can reach every bank in column j. The bank on the diagonal, at (i,i), is reachable only by processor i, in both modes, and serves as its local store. The whole fabric is in one global mode at a time. Because each bus has a single owner, there is no arbitration.

A control processor sets the mode. It can also start a spread. A spread copies each processor's diagonal bank into every bank of that processor's row, one word per cycle. When the spread is over, each column holds a copy of every processor's local data. Each processor can then read all of that data through its own column in column mode. In a typical system, one scalar control processor and the vector units together make up the `NPROC` ports.

Top module: `omx_fabric`

## Requirements
- R1: After a synchronous active-low reset, the fabric is in row mode (`mode_now` = 0). `spread_busy`, `spread_done`, every `rd_vld` and every `acc_err` are 0, and every word of every bank reads as zero.
- R2: Row mode is `mode_now` = 0, and an access declares row type with `acc_kind` = 0. In row mode, a row-type access by processor i targets bank (i, X) word W. Here X is the upper `log2(NPROC)` bits of that processor's address field and W is the lower `log2(WORDS)` bits. A write takes effect at the clock edge that samples it. A read returns the stored word on `rd_data` with `rd_vld` high in the following cycle.
- R3: Column mode is `mode_now` = 1, and an access declares column type with `acc_kind` = 1. In column mode, a column-type access by processor j with the same address split targets bank (X, j) word W, with the same write and read timing as in R2.
- R4: When an access's `acc_kind` differs from the current mode, the fabric raises `acc_err` for that processor in the next cycle. It writes nothing, and `rd_vld` stays low.
- R5: A `mode_chg` pulse loads `mode_sel` into the mode, visible on `mode_now` in the next cycle. This happens only in a cycle with no `acc_vld`, no `spread_go` and `spread_busy` low. Otherwise the request has no effect.
- R6: Once a spread is accepted, `spread_busy` is high for exactly `WORDS` cycles. In the k-th of those cycles, word k of bank (i,i) is copied into word k of every bank (i,j). `spread_done` is high for one cycle: the first cycle after `spread_busy` falls.
- R7: Any access presented while `spread_busy` is high is rejected with `acc_err` in the next cycle and changes no bank.
- R8: A `spread_go` is accepted only in row mode with `spread_busy` low. In column mode or during a running spread it has no effect.
- R9: The diagonal bank (i,i) is reached by processor i with index i in both modes. A word written there in one mode reads back in the other.
- R10: A processor write to its diagonal bank in the same cycle as an accepted `spread_go` is included in the copy made by that spread.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_chg | input | 1 | Request to load `mode_sel` into the global mode |
| mode_sel | input | 1 | Requested mode: 0 row, 1 column |
| spread_go | input | 1 | Start a diagonal-to-row spread |
| spread_busy | output | 1 | Spread in progress |
| spread_done | output | 1 | One-cycle pulse after the last spread word |
| mode_now | output | 1 | Current global mode: 0 row, 1 column |
| acc_vld | input | NPROC | Per-processor access request |
| acc_kind | input | NPROC | Per-processor access type: 0 row, 1 column |
| acc_we | input | NPROC | Per-processor write enable |
| acc_addr | input | NPROC*AW | Per-processor {bank index, word offset} |
| acc_wdata | input | NPROC*DW | Per-processor write data |
| rd_vld | output | NPROC | Per-processor read data valid |
| rd_data | output | NPROC*DW | Per-processor read data |
| acc_err | output | NPROC | Per-processor rejected-access flag |

## Verification
Two cases matter most because they can fall in the same cycle. The first is a processor write to its diagonal bank together with the `spread_go` that starts a copy of that bank. The bench drives both in one cycle, then sweeps every column in column mode and compares the copies against a behavioural model, which applies the write before the first copied word. The second is a mode change in the same cycle as traffic or a spread start. The bench provokes this both directly and in a long random phase, and judges it by comparing `mode_now` on every clock against the model, which lets the change land only in idle cycles.

// File: rtl/omx_pkg.sv
// Shared types for the orthogonal row/column memory fabric.
// Assumes nothing beyond a single global access mode.
package omx_pkg;

    typedef enum logic {
        MODE_ROW = 1'b0,
        MODE_COL = 1'b1
    } omx_mode_e;

endpackage

// File: rtl/omx_bank.sv
// One memory bank of the grid: a small register array with one shared
// address used for both the write and the combinational read.
// Assumes WORDS is a power of two of at least 2.
module omx_bank #(
    parameter int WORDS = 8,
    parameter int DW    = 16,
    localparam int OW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [OW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [WORDS];

    // Storage: clear on reset, otherwise take a write when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[w] <= '0;
            end
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Read port: current stored word at the shared address.
    assign rdata = mem[addr];

endmodule

// File: rtl/omx_mode_ctl.sv
// Global mode register. A mode change is applied only when nothing is
// in flight: no access request, no spread start and no running spread.
// Assumes the requester holds or repeats mode_chg until it is seen.
module omx_mode_ctl
    import omx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mode_chg,
    input  logic      mode_sel,
    input  logic      any_vld,
    input  logic      spread_go,
    input  logic      spread_busy,
    output omx_mode_e mode_q
);

    logic apply;

    // Change gate: idle fabric only.
    assign apply = mode_chg && !any_vld && !spread_go && !spread_busy;

    // Mode state: row after reset, loads the request when the gate is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_ROW;
        end else if (apply) begin
            mode_q <= omx_mode_e'(mode_sel);
        end
    end

    AST_MODE_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (spread_busy || any_vld || spread_go) |=> $stable(mode_q)); // R5

endmodule

// File: rtl/omx_spread_seq.sv
// Spread sequencer: walks the word offset from 0 to WORDS-1, one word
// per cycle, and pulses done in the cycle after the last word.
// Assumes a start is only legal in row mode while idle.
module omx_spread_seq #(
    parameter int WORDS = 8,
    localparam int OW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          row_mode,
    output logic          busy,
    output logic [OW-1:0] cnt,
    output logic          done
);

    localparam logic [OW-1:0] LAST = OW'(WORDS - 1);

    // Sequencer state: start, count words, finish with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= busy && (cnt == LAST);
            if (busy) begin
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (go && row_mode) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end
    end

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cnt == '0)); // R6
    AST_NO_START_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go && !row_mode) |=> !busy); // R8

endmodule

// File: rtl/omx_fabric.sv
// Orthogonal memory fabric: NPROC processors, NPROC x NPROC banks,
// exclusive row and column buses, one global mode, and a diagonal
// spread that copies bank (i,i) across row i.
// Assumes NPROC and WORDS are powers of two of at least 2.
module omx_fabric
    import omx_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int WORDS = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(NPROC),
    localparam int OW   = $clog2(WORDS),
    localparam int AW   = IW + OW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_chg,
    input  logic                mode_sel,
    input  logic                spread_go,
    output logic                spread_busy,
    output logic                spread_done,
    output logic                mode_now,
    input  logic [NPROC-1:0]    acc_vld,
    input  logic [NPROC-1:0]    acc_kind,
    input  logic [NPROC-1:0]    acc_we,
    input  logic [NPROC*AW-1:0] acc_addr,
    input  logic [NPROC*DW-1:0] acc_wdata,
    output logic [NPROC-1:0]    rd_vld,
    output logic [NPROC*DW-1:0] rd_data,
    output logic [NPROC-1:0]    acc_err
);

    omx_mode_e       mode_q;
    logic [OW-1:0]   spread_cnt;
    logic            any_vld;
    logic [IW-1:0]   p_idx  [NPROC];
    logic [OW-1:0]   p_off  [NPROC];
    logic [DW-1:0]   p_wd   [NPROC];
    logic            p_ok   [NPROC];
    logic [DW-1:0]   bank_rd [NPROC*NPROC];

    assign any_vld  = |acc_vld;
    assign mode_now = logic'(mode_q);

    omx_mode_ctl u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_chg    (mode_chg),
        .mode_sel    (mode_sel),
        .any_vld     (any_vld),
        .spread_go   (spread_go),
        .spread_busy (spread_busy),
        .mode_q      (mode_q)
    );

    omx_spread_seq #(.WORDS(WORDS)) u_spread (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (spread_go),
        .row_mode (mode_q == MODE_ROW),
        .busy     (spread_busy),
        .cnt      (spread_cnt),
        .done     (spread_done)
    );

    // Processor ports: split the address, qualify the access, register results.
    for (genvar p = 0; p < NPROC; p++) begin : g_port
        logic [DW-1:0] p_rd;
        logic          rvld_r;
        logic          err_r;
        logic [DW-1:0] rd_r;

        assign p_idx[p] = acc_addr[p*AW+OW +: IW];
        assign p_off[p] = acc_addr[p*AW +: OW];
        assign p_wd[p]  = acc_wdata[p*DW +: DW];
        assign p_ok[p]  = acc_vld[p] && !spread_busy
                          && (acc_kind[p] == logic'(mode_q));

        // Bus read select: own row in row mode, own column in column mode.
        always_comb begin
            if (mode_q == MODE_ROW) begin
                p_rd = bank_rd[p*NPROC + int'(p_idx[p])];
            end else begin
                p_rd = bank_rd[int'(p_idx[p])*NPROC + p];
            end
        end

        // Result registers: read data, valid and reject flag one cycle later.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rvld_r <= 1'b0;
                err_r  <= 1'b0;
                rd_r   <= '0;
            end else begin
                rvld_r <= p_ok[p] && !acc_we[p];
                err_r  <= acc_vld[p] && !p_ok[p];
                if (p_ok[p] && !acc_we[p]) begin
                    rd_r <= p_rd;
                end
            end
        end

        assign rd_vld[p]            = rvld_r;
        assign acc_err[p]           = err_r;
        assign rd_data[p*DW +: DW]  = rd_r;

        AST_ERR_NOT_RVLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(acc_err[p] && rd_vld[p])); // R4
        AST_KIND_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_vld[p] && (acc_kind[p] != mode_now)) |=> acc_err[p]); // R4
        AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
            (spread_busy && acc_vld[p]) |=> (acc_err[p] && !rd_vld[p])); // R7
    end

    // Bank grid: bank (i,j) hangs on row bus i and column bus j.
    for (genvar i = 0; i < NPROC; i++) begin : g_row
        for (genvar j = 0; j < NPROC; j++) begin : g_col
            logic          row_hit;
            logic          col_hit;
            logic          bwe;
            logic [OW-1:0] baddr;
            logic [DW-1:0] bwd;

            assign row_hit = (mode_q == MODE_ROW) && p_ok[i] && (p_idx[i] == IW'(j));
            assign col_hit = (mode_q == MODE_COL) && p_ok[j] && (p_idx[j] == IW'(i));

            // Bank port steering: spread copy wins, else the owning bus.
            always_comb begin
                if (spread_busy) begin
                    bwe   = (i != j);
                    baddr = spread_cnt;
                    bwd   = bank_rd[i*NPROC + i];
                end else if (mode_q == MODE_ROW) begin
                    bwe   = row_hit && acc_we[i];
                    baddr = p_off[i];
                    bwd   = p_wd[i];
                end else begin
                    bwe   = col_hit && acc_we[j];
                    baddr = p_off[j];
                    bwd   = p_wd[j];
                end
            end

            omx_bank #(.WORDS(WORDS), .DW(DW)) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (bwe),
                .addr  (baddr),
                .wdata (bwd),
                .rdata (bank_rd[i*NPROC + j])
            );
        end
    end

endmodule

// File: tb/omx_fabric_tb.sv
// Bench for omx_fabric: behavioural reference model updated at every
// rising edge and compared with every output at every falling edge.
module omx_fabric_tb_top;

    localparam int NP = 4;
    localparam int NW = 8;
    localparam int DW = 16;
    localparam int IW = $clog2(NP);
    localparam int OW = $clog2(NW);
    localparam int AW = IW + OW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_chg = 1'b0;
    logic             mode_sel = 1'b0;
    logic             spread_go = 1'b0;
    logic             spread_busy;
    logic             spread_done;
    logic             mode_now;
    logic [NP-1:0]    acc_vld = '0;
    logic [NP-1:0]    acc_kind = '0;
    logic [NP-1:0]    acc_we = '0;
    logic [NP*AW-1:0] acc_addr = '0;
    logic [NP*DW-1:0] acc_wdata = '0;
    logic [NP-1:0]    rd_vld;
    logic [NP*DW-1:0] rd_data;
    logic [NP-1:0]    acc_err;

    always #4 clk = ~clk;

    omx_fabric #(.NPROC(NP), .WORDS(NW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_chg(mode_chg), .mode_sel(mode_sel),
        .spread_go(spread_go), .spread_busy(spread_busy), .spread_done(spread_done),
        .mode_now(mode_now), .acc_vld(acc_vld), .acc_kind(acc_kind), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_vld(rd_vld),
        .rd_data(rd_data), .acc_err(acc_err)
    );

    // Reference model state.
    logic [DW-1:0] ref_mem [NP][NP][NW];
    bit            e_mode, e_busy, e_done;
    int            e_cnt;
    bit            e_rvld [NP];
    bit            e_err  [NP];
    logic [DW-1:0] e_rd   [NP];
    bit            started = 0;
    bit            wd_fired = 0;
    int            vectors = 0;
    int            miscompares = 0;
    int            cycles = 0;

    // Model: one step per rising edge from the inputs driven before it.
    always @(posedge clk) begin
        started <= 1'b1;
        cycles  <= cycles + 1;
        if (!rst_n) begin
            e_mode = 0; e_busy = 0; e_done = 0; e_cnt = 0;
            for (int p = 0; p < NP; p++) begin
                e_rvld[p] = 0; e_err[p] = 0; e_rd[p] = '0;
            end
            for (int a = 0; a < NP; a++)
                for (int b = 0; b < NP; b++)
                    for (int w = 0; w < NW; w++) ref_mem[a][b][w] = '0;
        end else begin
            bit ob, om;
            ob = e_busy;
            om = e_mode;
            for (int p = 0; p < NP; p++) begin
                e_rvld[p] = 0;
                e_err[p]  = 0;
                if (acc_vld[p]) begin
                    if (ob || (acc_kind[p] != om)) begin
                        e_err[p] = 1;
                    end else begin
                        int idx, off, r, c;
                        idx = int'(acc_addr[p*AW+OW +: IW]);
                        off = int'(acc_addr[p*AW +: OW]);
                        r = om ? idx : p;
                        c = om ? p : idx;
                        if (acc_we[p]) ref_mem[r][c][off] = acc_wdata[p*DW +: DW];
                        else begin
                            e_rd[p]   = ref_mem[r][c][off];
                            e_rvld[p] = 1;
                        end
                    end
                end
            end
            e_done = 0;
            if (ob) begin
                for (int a = 0; a < NP; a++)
                    for (int b = 0; b < NP; b++) ref_mem[a][b][e_cnt] = ref_mem[a][a][e_cnt];
                if (e_cnt == NW - 1) begin
                    e_busy = 0; e_cnt = 0; e_done = 1;
                end else e_cnt = e_cnt + 1;
            end else if (spread_go && !om) begin
                e_busy = 1; e_cnt = 0;
            end
            if (mode_chg && !(|acc_vld) && !spread_go && !ob) e_mode = mode_sel;
        end
    end

    task automatic fail(string req, string what, longint act, longint exp);
        miscompares++;
        $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    endtask

    // Compare every output against the model away from the rising edge.
    always @(negedge clk) begin
        if (started && !wd_fired) begin
            vectors++;
            if (mode_now !== e_mode) fail("R5", "mode_now", mode_now, e_mode);
            if (spread_busy !== e_busy) fail("R6/R8", "spread_busy", spread_busy, e_busy);
            if (spread_done !== e_done) fail("R6", "spread_done", spread_done, e_done);
            for (int p = 0; p < NP; p++) begin
                if (acc_err[p] !== e_err[p]) fail("R4/R7", $sformatf("acc_err[%0d]", p), acc_err[p], e_err[p]);
                if (rd_vld[p] !== e_rvld[p]) fail("R2/R3", $sformatf("rd_vld[%0d]", p), rd_vld[p], e_rvld[p]);
                if (e_rvld[p] && (rd_data[p*DW +: DW] !== e_rd[p]))
                    fail(e_mode ? "R3/R9/R6" : "R2/R1", $sformatf("rd_data[%0d]", p),
                         rd_data[p*DW +: DW], e_rd[p]);
            end
        end
    end

    task automatic idle_in();
        acc_vld = '0; acc_kind = '0; acc_we = '0; acc_addr = '0; acc_wdata = '0;
        mode_chg = 0; mode_sel = 0; spread_go = 0;
    endtask

    task automatic acc(int p, bit kind, bit we, int idx, int off, logic [DW-1:0] d);
        acc_vld[p]            = 1'b1;
        acc_kind[p]           = kind;
        acc_we[p]             = we;
        acc_addr[p*AW +: AW]  = AW'((idx << OW) | off);
        acc_wdata[p*DW +: DW] = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
        idle_in();
    endtask

    task automatic sweep_read(bit kind);
        for (int idx = 0; idx < NP; idx++)
            for (int off = 0; off < NW; off++) begin
                for (int p = 0; p < NP; p++) acc(p, kind, 0, idx, off, '0);
                step();
            end
    endtask

    task automatic set_mode(bit m);
        mode_chg = 1; mode_sel = m;
        step();
    endtask

    // Watchdog: an overrun is a failed check and still prints the summary.
    always @(posedge clk) begin
        if (cycles > 150000 && !wd_fired) begin
            wd_fired = 1;
            miscompares++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        idle_in();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst_n = 1;
        // R1: reset state, all banks zero through row reads
        step(); step();
        sweep_read(0);

        // R2: row-mode writes of a distinct pattern by every processor
        for (int idx = 0; idx < NP; idx++)
            for (int off = 0; off < NW; off++) begin
                for (int p = 0; p < NP; p++) acc(p, 0, 1, idx, off, DW'(16'h4000 + p*256 + idx*16 + off));
                step();
            end
        sweep_read(0);

        // R5: change blocked by a same-cycle access, then applied when idle
        mode_chg = 1; mode_sel = 1; acc(0, 0, 0, 1, 2, '0);
        step();
        set_mode(1);

        // R3, R9: column sweep sees the row data transposed, diagonal shared
        sweep_read(1);
        acc(2, 1, 1, 2, 5, 16'hD1A6);  // R9 diagonal write in column mode
        acc(1, 1, 1, 3, 0, 16'hC011);
        step();
        set_mode(0);
        acc(2, 0, 0, 2, 5, '0);        // R9 diagonal read back in row mode
        acc(3, 0, 0, 1, 0, '0);        // R3 bank (3,1) written from column 1
        step();
        set_mode(1);

        // R4: wrong-kind write rejected, location unchanged
        acc(0, 0, 1, 0, 0, 16'hBAD0);
        step();
        acc(0, 1, 0, 0, 0, '0);
        step();

        // R8: spread start ignored in column mode
        spread_go = 1;
        step(); step();
        set_mode(0);

        // R10: diagonal write in the same cycle as the spread start
        spread_go = 1; acc(1, 0, 1, 1, 0, 16'h5EED);
        step();
        // R7, R8, R5: accesses, second start and mode change while busy
        acc(0, 0, 0, 0, 0, '0); acc(3, 0, 1, 2, 1, 16'hFFFF);
        spread_go = 1; mode_chg = 1; mode_sel = 1;
        step();
        // R6: let the spread finish and the done pulse appear
        repeat (NW + 2) step();
        set_mode(1);
        sweep_read(1);

        // Random traffic across all functions
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 5) begin mode_chg = 1; mode_sel = 1'($urandom); end
            else if (r < 8) spread_go = 1;
            for (int p = 0; p < NP; p++)
                if ($urandom % 3 == 0)
                    acc(p, ($urandom % 8 == 0) ? !e_mode : e_mode, 1'($urandom),
                        int'($urandom % NP), int'($urandom % NW), DW'($urandom));
            step();
        end
        repeat (NW + 2) step();
        set_mode(1);
        sweep_read(1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule